// File: doc/BRIEF.md
# Data-Dependent Fail-First Loop Sequencer

This block steps a vector loop through its element indices, one element per clock. It sends out the index of the current element. The datapath around it returns that element's 4-bit condition field and a floating-point exception flag in the same cycle. The sequencer applies a branch-style test to a chosen condition bit. The first element that fails the test ends the loop, and the block reports a shortened vector length. That length is exact: it counts only the elements stepped through before the failure, plus the failing element itself when the inclusive option is in force.

A controller loads the loop length, the direction, the test mode and a predicate mask with a single start pulse. It then receives one commit strobe per element whose result may be kept, and a done pulse that carries the new vector length. Elements removed by the predicate are stepped over without a test. A loop that has no failure keeps its original length. A failure on the very first element may produce a length of zero.

Top module: `dd_ffirst_seq`

## Requirements
- R1: After a start is accepted, idx_o shows the elements one per cycle. In forward order they run 0, 1, …, VL-1. With rev_i set they run VL-1 down to 0.
- R2: With rec_i=1 the tested bit is cond_i[sel_i], where cond_i[3]=lt, [2]=gt, [1]=eq and [0]=so. An element fails when that bit equals inv_i.
- R3: With rec_i=0 the tested bit is always cond_i[1] (eq), whatever sel_i is, and res_we_o never rises. With rec_i=1, res_we_o pulses together with every commit.
- R4: commit_o, cidx_o, res_we_o, fpx_o, done_o and new_vl_o are registered. They change at the clock edge that ends the cycle in which the element sits on idx_o. On a failure, done_o rises at that edge, busy_o falls, and no element after the failing one is ever committed.
- R5: new_vl_o is the number of loop steps taken before the failing element, where masked elements also count as steps. When inclusive mode is in force (incl_i=1 and rec_i=0), the count includes the failing element, and that element is committed. When rec_i=1, incl_i has no effect.
- R6: A failure on the first element with inclusive mode off gives new_vl_o=0 and no commit.
- R7: A loop with no failure ends with new_vl_o equal to VL, on the same edge as the last element's commit. A start with VL=0 gives done_o on the next edge with new_vl_o=0.
- R8: fpx_i=1 on an unmasked element counts as a failure. fpx_o pulses together with done_o only when inclusive mode is in force.
- R9: An element whose bit in pred_i is 0 is never tested and produces no commit. Its condition and exception inputs have no effect.
- R10: A start_i that arrives while busy_o=1 is ignored.
- R11: After reset, busy_o, commit_o, done_o, res_we_o and fpx_o are 0, and new_vl_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a loop (accepted only when idle) |
| vl_i | input | 7 | Loop length, 0 to 64 |
| rev_i | input | 1 | Reverse element order |
| rec_i | input | 1 | Record mode: select tested bit with sel_i |
| sel_i | input | 2 | Condition bit select (3=lt, 2=gt, 1=eq, 0=so) |
| inv_i | input | 1 | Test fails when selected bit equals this |
| incl_i | input | 1 | Count the failing element (only when rec_i=0) |
| pred_i | input | 64 | Predicate mask, bit n enables element n |
| cond_i | input | 4 | Condition field of the element on idx_o |
| fpx_i | input | 1 | Floating-point exception of the element on idx_o |
| busy_o | output | 1 | Loop in progress |
| idx_o | output | 6 | Element currently evaluated |
| commit_o | output | 1 | Element cidx_o is kept |
| cidx_o | output | 6 | Index of the committed element |
| res_we_o | output | 1 | Arithmetic result of cidx_o may be written |
| fpx_o | output | 1 | Raise the exception of the failing element |
| done_o | output | 1 | Loop finished, new_vl_o valid |
| new_vl_o | output | 7 | Truncated vector length |

## Verification
The final commit and the end of the loop can fall on the same edge. This happens on the last element of a loop that does not fail, and on a failing element in inclusive mode. Both cases are forced by directed vectors: a full-length pass, inclusive failures on the first element and on the middle elements, and an exception failure. They also appear often in random loops. In each of these, the bench samples the edge that carries done_o. It requires that edge to hold exactly the expected last commit, with the right index, and the expected length. An extra commit, or a missing one, counts as a miscompare.

// File: rtl/ffs_pkg.sv
package ffs_pkg;
  localparam int CB_SO = 0;
  localparam int CB_EQ = 1;
  localparam int CB_GT = 2;
  localparam int CB_LT = 3;

  typedef struct packed {
    logic       rec;
    logic       inv;
    logic       incl;
    logic [1:0] sel;
  } ffs_mode_t;
endpackage

// File: rtl/ffs_order.sv
module ffs_order #(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int IW  = $clog2(MAX_VL)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           adv,
  input  logic           rev,
  input  logic [VLW-1:0] vl,
  output logic [VLW-1:0] step,
  output logic [IW-1:0]  idx,
  output logic           last
);
  logic [VLW-1:0] vl_q;
  logic           rev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step  <= '0;
      idx   <= '0;
      vl_q  <= '0;
      rev_q <= 1'b0;
    end else if (load) begin
      step  <= '0;
      vl_q  <= vl;
      rev_q <= rev;
      idx   <= rev ? IW'(vl - VLW'(1)) : '0;
    end else if (adv) begin
      step <= step + VLW'(1);
      idx  <= rev_q ? idx - IW'(1) : idx + IW'(1);
    end
  end

  assign last = (step == vl_q - VLW'(1));
endmodule

// File: rtl/ffs_test.sv
module ffs_test
  import ffs_pkg::*;
(
  input  logic [3:0] cond,
  input  logic       fpx,
  input  logic       rec,
  input  logic [1:0] sel,
  input  logic       inv,
  output logic       fail
);
  logic tbit;
  always_comb begin
    tbit = rec ? cond[sel] : cond[CB_EQ];
    fail = (tbit == inv) | fpx;
  end
endmodule

// File: rtl/dd_ffirst_seq.sv
module dd_ffirst_seq
  import ffs_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int IW  = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic              rev_i,
  input  logic              rec_i,
  input  logic [1:0]        sel_i,
  input  logic              inv_i,
  input  logic              incl_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic [3:0]        cond_i,
  input  logic              fpx_i,
  output logic              busy_o,
  output logic [IW-1:0]     idx_o,
  output logic              commit_o,
  output logic [IW-1:0]     cidx_o,
  output logic              res_we_o,
  output logic              fpx_o,
  output logic              done_o,
  output logic [VLW-1:0]    new_vl_o
);
  ffs_mode_t         mode_q;
  logic [MAX_VL-1:0] pred_q;
  logic              busy_q;
  logic [VLW-1:0]    step;
  logic [IW-1:0]     idx;
  logic              last, tfail, active, act_fail, go, load, adv;

  assign go       = start_i & ~busy_q;
  assign load     = go & (vl_i != '0);
  assign active   = pred_q[idx];
  assign act_fail = active & tfail;
  assign adv      = busy_q & ~act_fail & ~last;

  ffs_order #(.MAX_VL(MAX_VL)) u_order (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .rev(rev_i),
    .vl(vl_i), .step(step), .idx(idx), .last(last)
  );

  ffs_test u_test (
    .cond(cond_i), .fpx(fpx_i), .rec(mode_q.rec), .sel(mode_q.sel),
    .inv(mode_q.inv), .fail(tfail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      mode_q   <= '0;
      pred_q   <= '0;
      done_o   <= 1'b0;
      commit_o <= 1'b0;
      cidx_o   <= '0;
      res_we_o <= 1'b0;
      fpx_o    <= 1'b0;
      new_vl_o <= '0;
    end else begin
      done_o   <= 1'b0;
      commit_o <= 1'b0;
      res_we_o <= 1'b0;
      fpx_o    <= 1'b0;
      if (go) begin
        mode_q.rec  <= rec_i;
        mode_q.inv  <= inv_i;
        mode_q.incl <= incl_i & ~rec_i;
        mode_q.sel  <= sel_i;
        pred_q      <= pred_i;
        if (vl_i == '0) begin
          done_o   <= 1'b1;
          new_vl_o <= '0;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (busy_q) begin
        cidx_o <= idx;
        if (act_fail) begin
          busy_q   <= 1'b0;
          done_o   <= 1'b1;
          new_vl_o <= step + VLW'(mode_q.incl);
          commit_o <= mode_q.incl;
          res_we_o <= mode_q.incl & mode_q.rec;
          fpx_o    <= fpx_i & mode_q.incl;
        end else begin
          commit_o <= active;
          res_we_o <= active & mode_q.rec;
          if (last) begin
            busy_q   <= 1'b0;
            done_o   <= 1'b1;
            new_vl_o <= step + VLW'(1);
          end
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx;
endmodule

// File: rtl/ffs_chk.sv
module ffs_chk #(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int IW  = $clog2(MAX_VL)
) (
  input logic           clk,
  input logic           rst,
  input logic           start_i,
  input logic [VLW-1:0] vl_i,
  input logic           busy_o,
  input logic [IW-1:0]  idx_o,
  input logic           commit_o,
  input logic [IW-1:0]  cidx_o,
  input logic           res_we_o,
  input logic           fpx_o,
  input logic           done_o,
  input logic [VLW-1:0] new_vl_o
);
  logic [VLW-1:0] q_vl;
  always_ff @(posedge clk) begin
    if (rst) q_vl <= '0;
    else if (start_i && !busy_o) q_vl <= vl_i;
  end

  a_r1_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (VLW'(idx_o) < q_vl));
  a_r4_commit_in_range: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (VLW'(cidx_o) < q_vl));
  a_r5_never_grows: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (new_vl_o <= q_vl));
  a_r3_write_needs_commit: assert property (@(posedge clk) disable iff (rst)
    res_we_o |-> commit_o);
  a_r8_raise_at_end: assert property (@(posedge clk) disable iff (rst)
    fpx_o |-> (done_o && commit_o));
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    (done_o && new_vl_o != '0) |-> !busy_o);
endmodule

bind dd_ffirst_seq ffs_chk #(.MAX_VL(MAX_VL)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .vl_i(vl_i), .busy_o(busy_o),
  .idx_o(idx_o), .commit_o(commit_o), .cidx_o(cidx_o), .res_we_o(res_we_o),
  .fpx_o(fpx_o), .done_o(done_o), .new_vl_o(new_vl_o)
);

// File: tb/sim_dd_ffirst_seq.sv
module sim_dd_ffirst_seq;
  localparam int MAXV = 64;
  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, rev_i = 1'b0, rec_i = 1'b0, inv_i = 1'b0, incl_i = 1'b0;
  logic [6:0] vl_i = '0;
  logic [1:0] sel_i = '0;
  logic [63:0] pred_i = '1;
  logic [3:0] cond_i;
  logic fpx_i;
  logic busy_o, commit_o, res_we_o, fpx_o, done_o;
  logic [5:0] idx_o, cidx_o;
  logic [6:0] new_vl_o;

  logic [3:0] c_arr [MAXV];
  logic       f_arr [MAXV];
  int n_chk = 0, n_bad = 0;

  int exp_n, exp_vl;
  int exp_idx [MAXV];
  logic exp_fx;

  always #4 clk = ~clk;

  always_comb begin
    cond_i = c_arr[idx_o];
    fpx_i  = f_arr[idx_o];
  end

  dd_ffirst_seq u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .vl_i(vl_i), .rev_i(rev_i),
    .rec_i(rec_i), .sel_i(sel_i), .inv_i(inv_i), .incl_i(incl_i),
    .pred_i(pred_i), .cond_i(cond_i), .fpx_i(fpx_i), .busy_o(busy_o),
    .idx_o(idx_o), .commit_o(commit_o), .cidx_o(cidx_o), .res_we_o(res_we_o),
    .fpx_o(fpx_o), .done_o(done_o), .new_vl_o(new_vl_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Reference: computed from the requirements
  task automatic model();
    int vl = int'(vl_i);
    logic incl = incl_i & ~rec_i;
    exp_n = 0; exp_vl = vl; exp_fx = 1'b0;
    for (int k = 0; k < vl; k++) begin
      int i = rev_i ? vl - 1 - k : k;
      logic tb, fl;
      if (!pred_i[i]) continue;
      tb = rec_i ? c_arr[i][sel_i] : c_arr[i][1];
      fl = (tb == inv_i) | f_arr[i];
      if (fl) begin
        if (incl) begin exp_idx[exp_n] = i; exp_n++; end
        exp_vl = k + int'(incl);
        exp_fx = f_arr[i] & incl;
        break;
      end
      exp_idx[exp_n] = i; exp_n++;
    end
  endtask

  // fill all tested bits with passing values, no exceptions
  task automatic fill_pass();
    for (int i = 0; i < MAXV; i++) begin
      c_arr[i] = 4'($urandom);
      c_arr[i][rec_i ? int'(sel_i) : 1] = ~inv_i;
      f_arr[i] = 1'b0;
    end
  endtask

  task automatic run(input string tag, input bit poke = 0);
    int got = 0, cyc = 0;
    logic fx = 1'b0, fin = 1'b0;
    int nvl = -1;
    model();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (cyc < 200) begin
      if (poke && cyc == 3) begin
        start_i = 1'b1; vl_i = 7'd2; rev_i = ~rev_i; // R10: must be ignored
      end else if (poke && cyc == 4) begin
        start_i = 1'b0;
      end
      if (commit_o) begin
        if (got < exp_n) chk("R1 commit index", int'(cidx_o), exp_idx[got]);
        chk("R3 result write", int'(res_we_o), int'(rec_i & ~poke));
        got++;
      end
      if (done_o) begin fin = 1'b1; nvl = int'(new_vl_o); fx = fpx_o; break; end
      @(negedge clk); cyc++;
    end
    chk({tag, " done seen"}, int'(fin), 1);
    chk("R4 commit count", got, exp_n);
    chk({tag, " new length"}, nvl, exp_vl);
    chk("R8 exception raise", int'(fx), int'(exp_fx));
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0ff1));
    for (int i = 0; i < MAXV; i++) begin c_arr[i] = '0; f_arr[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 busy after reset", int'(busy_o), 0);
    chk("R11 done after reset", int'(done_o), 0);
    chk("R11 commit after reset", int'(commit_o | res_we_o | fpx_o), 0);
    chk("R11 length after reset", int'(new_vl_o), 0);

    // R6: eq test fails at element 0, exclusive
    rec_i = 0; inv_i = 0; incl_i = 0; rev_i = 0; vl_i = 8; pred_i = '1;
    fill_pass(); c_arr[0][1] = 1'b0; sel_i = 2'd3;
    run("R6");
    // R5: same but inclusive
    incl_i = 1; run("R5");
    // R2: record mode, lt bit, inv=1, reverse, failing at 6; incl ignored
    rec_i = 1; sel_i = 2'd3; inv_i = 1; incl_i = 1; rev_i = 1; vl_i = 10;
    fill_pass(); c_arr[6][3] = 1'b1; c_arr[6][1] = 1'b1;
    run("R2");
    // R3: rec=0 tests eq regardless of sel; lt bit poisoned
    rec_i = 0; sel_i = 2'd3; inv_i = 0; incl_i = 0; rev_i = 0; vl_i = 12;
    fill_pass();
    for (int i = 0; i < MAXV; i++) c_arr[i][3] = 1'b0;
    c_arr[9][1] = 1'b0;
    run("R3");
    // R7: full 64 pass, then VL=0
    vl_i = 64; fill_pass(); run("R7");
    vl_i = 0; run("R7");
    // R8: exception at 3, inclusive then exclusive
    vl_i = 16; incl_i = 1; fill_pass(); f_arr[3] = 1'b1; run("R8");
    incl_i = 0; run("R8");
    // R9: masked failing element and masked exception are skipped
    vl_i = 20; fill_pass(); c_arr[5][1] = 1'b0; f_arr[7] = 1'b1;
    pred_i = '1; pred_i[5] = 1'b0; pred_i[7] = 1'b0; pred_i[2] = 1'b0;
    run("R9");
    // R10: start while busy ignored (expected from original settings)
    pred_i = '1; rev_i = 0; rec_i = 0; vl_i = 20; fill_pass();
    run("R10", 1);
    rev_i = 0;

    for (int v = 0; v < 300; v++) begin
      vl_i   = 7'($urandom_range(0, 64));
      rev_i  = 1'($urandom); rec_i = 1'($urandom); inv_i = 1'($urandom);
      incl_i = 1'($urandom); sel_i = 2'($urandom);
      pred_i = {$urandom, $urandom} | {$urandom, $urandom} | {$urandom, $urandom};
      fill_pass();
      for (int i = 0; i < MAXV; i++) begin
        if ($urandom_range(0, 29) == 0) c_arr[i][rec_i ? int'(sel_i) : 1] = inv_i;
        f_arr[i] = ($urandom_range(0, 59) == 0);
      end
      run("R5");
    end
    summary();
  end
endmodule